// File: doc/BRIEF.md
# Grouped State Backup Sequencer

This block sequences the retention of a processor's state around a full power removal. When a shutdown is requested, it first asks the cache to write back its dirty lines. Once the cache acknowledges, it copies the retained registers into a shadow bank that stands in for non-volatile storage. Only then does it tell the power controller that power may be cut. When power-good returns, it reloads the registers from the shadow bank, and only after that lets the core leave its hold.

Copying every register at once would draw a large peak write current. The sequencer therefore splits the retained set into groups of at most `GRP_SIZE` registers. It visits the groups one after another and holds each group's strobe for a programmable number of cycles, which covers the slow shadow write and the faster shadow read. The group count is the register count divided by the group size, rounded up. The last group may be partial.

Top module: `pwr_state_seq`

## Requirements
- R1: After a synchronous reset, `flush_req_o`, `save_stb_o`, `load_stb_o`, `pwr_off_ok_o` and `core_hold_o` are all low, and the block is in the running state.
- R2: A `shutdown_req_i` pulse seen in the running state raises `flush_req_o` and `core_hold_o` one cycle later. No save strobe is driven before the flush is acknowledged.
- R3: `flush_req_o` stays high until `flush_ack_i` is seen while it is high, and it falls in the following cycle.
- R4: After the flush acknowledge, bit g of `save_stb_o` (group g covers register bits g*GRP_SIZE up to the lesser of (g+1)*GRP_SIZE and NUM_REGS) is driven in ascending order of g. Exactly one bit is high at a time, each for exactly SAVE_HOLD consecutive cycles.
- R5: At the end of the save, `shadow_q_o` equals the value `core_state_i` had during the save. `shadow_q_o` never changes in a cycle that follows one without a save strobe.
- R6: `pwr_off_ok_o` rises in the cycle after the last save strobe and stays high while `pwr_good_i` is high. It falls two cycles after `pwr_good_i` is seen low.
- R7: No load strobe is driven while power-good is low. Once `pwr_good_i` returns, bit g of `load_stb_o` is driven in ascending order of g, exactly one at a time, each for LOAD_HOLD consecutive cycles.
- R8: `core_hold_o` is high through every save and load strobe, and it falls in the cycle after the last load strobe.
- R9: A `shutdown_req_i` pulse seen while power is down or a restore is running is deferred. When the restore ends, a new flush request starts without any further request.
- R10: A `shutdown_req_i` pulse seen during the flush, save or power-off wait is ignored. No flush follows the next restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shutdown_req_i | input | 1 | Request to retain state and power off |
| pwr_good_i | input | 1 | Supply present and stable |
| flush_ack_i | input | 1 | Cache write-back of dirty lines complete |
| core_state_i | input | NUM_REGS | Live values of the retained registers |
| flush_req_o | output | 1 | Request for dirty-line write-back |
| save_stb_o | output | NUM_GRP | Per-group shadow write strobe |
| load_stb_o | output | NUM_GRP | Per-group restore strobe into the core registers |
| shadow_q_o | output | NUM_REGS | Shadow bank contents |
| pwr_off_ok_o | output | 1 | Power may be removed |
| core_hold_o | output | 1 | Core held stalled |

## Verification
The bench builds the block with 37 registers in groups of 10, a save hold of 3 cycles and a load hold of 2 cycles. This gives four groups with a partial last one, so the full strobe order, the per-group hold lengths and the partial-group slice of the shadow bank can all be traced within a few dozen cycles. Unequal hold values also separate the save and restore timing. Random register contents, random flush-acknowledge and power-off delays, and shutdown pulses injected mid-save and mid-restore reach both the deferral and the ignore paths.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_FLUSH = 3'd1,
    ST_SAVE  = 3'd2,
    ST_OFF   = 3'd3,
    ST_DOWN  = 3'd4,
    ST_LOAD  = 3'd5
  } seq_state_t;
endpackage

// File: rtl/pss_step_walker.sv
// Walks group index 0..NUM_GRP-1, spending HOLD cycles on each group.
module pss_step_walker #(
  parameter int NUM_GRP = 4,
  parameter int HOLD    = 1,
  localparam int GW = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active_i,
  output logic [GW-1:0] grp_o,
  output logic          final_o
);
  logic [CW-1:0] cnt_q;
  logic [GW-1:0] grp_q;
  logic          cnt_end;
  logic          grp_end;

  assign cnt_end = (cnt_q == CW'(HOLD - 1));
  assign grp_end = (grp_q == GW'(NUM_GRP - 1));

  always_ff @(posedge clk) begin
    if (rst || !active_i) begin
      cnt_q <= '0;
      grp_q <= '0;
    end else if (cnt_end) begin
      cnt_q <= '0;
      if (!grp_end) grp_q <= grp_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign grp_o   = grp_q;
  assign final_o = active_i && grp_end && cnt_end;
endmodule

// File: rtl/pss_strobe_dec.sv
// Registered one-hot decode of the current group index.
module pss_strobe_dec #(
  parameter int NUM_GRP = 4,
  localparam int GW = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_i,
  input  logic [GW-1:0]      grp_i,
  output logic [NUM_GRP-1:0] stb_o
);
  logic [NUM_GRP-1:0] stb_n;

  always_comb begin
    for (int g = 0; g < NUM_GRP; g++) begin
      stb_n[g] = en_i && (grp_i == GW'(g));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stb_o <= '0;
    else     stb_o <= stb_n;
  end
endmodule

// File: rtl/pss_shadow_bank.sv
// Duplicated register bank standing in for non-volatile storage.
// Deliberately not reset: its contents must outlive a power cycle.
module pss_shadow_bank #(
  parameter int NUM_REGS = 1644,
  parameter int GRP_SIZE = 500,
  localparam int NUM_GRP = (NUM_REGS + GRP_SIZE - 1) / GRP_SIZE
) (
  input  logic                clk,
  input  logic [NUM_GRP-1:0]  wr_i,
  input  logic [NUM_REGS-1:0] din_i,
  output logic [NUM_REGS-1:0] q_o
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int LO = g * GRP_SIZE;
    localparam int W  = (NUM_REGS - LO < GRP_SIZE) ? (NUM_REGS - LO) : GRP_SIZE;
    logic [W-1:0] bank_q;

    always_ff @(posedge clk) begin
      if (wr_i[g]) bank_q <= din_i[LO +: W];
    end

    assign q_o[LO +: W] = bank_q;
  end
endmodule

// File: rtl/pss_ctrl.sv
// Shutdown / power-up state machine.
module pss_ctrl
  import pss_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       shutdown_req_i,
  input  logic       pwr_good_i,
  input  logic       flush_ack_i,
  input  logic       save_final_i,
  input  logic       load_final_i,
  output seq_state_t state_o,
  output logic       flush_req_o,
  output logic       pwr_off_ok_o,
  output logic       core_hold_o
);
  seq_state_t st_q, st_n;
  logic       pend_q;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_RUN:   if (shutdown_req_i || pend_q)    st_n = ST_FLUSH;
      ST_FLUSH: if (flush_ack_i && flush_req_o)  st_n = ST_SAVE;
      ST_SAVE:  if (save_final_i)                st_n = ST_OFF;
      ST_OFF:   if (!pwr_good_i)                 st_n = ST_DOWN;
      ST_DOWN:  if (pwr_good_i)                  st_n = ST_LOAD;
      ST_LOAD:  if (load_final_i)                st_n = ST_RUN;
      default:                                   st_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_RUN;
      pend_q       <= 1'b0;
      flush_req_o  <= 1'b0;
      pwr_off_ok_o <= 1'b0;
      core_hold_o  <= 1'b0;
    end else begin
      st_q <= st_n;
      if (st_q == ST_RUN)
        pend_q <= 1'b0;
      else if ((st_q == ST_DOWN || st_q == ST_LOAD) && shutdown_req_i)
        pend_q <= 1'b1;
      flush_req_o  <= (st_n == ST_FLUSH);
      // one cycle behind the state so the last group strobe has ended
      pwr_off_ok_o <= (st_q == ST_OFF);
      // covers the trailing load strobe, which lags the state by a cycle
      core_hold_o  <= (st_n != ST_RUN) || (st_q == ST_LOAD);
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
  import pss_pkg::*;
#(
  parameter int NUM_REGS  = 1644,
  parameter int GRP_SIZE  = 500,
  parameter int SAVE_HOLD = 1,
  parameter int LOAD_HOLD = 1,
  localparam int NUM_GRP  = (NUM_REGS + GRP_SIZE - 1) / GRP_SIZE
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shutdown_req_i,
  input  logic                pwr_good_i,
  input  logic                flush_ack_i,
  input  logic [NUM_REGS-1:0] core_state_i,
  output logic                flush_req_o,
  output logic [NUM_GRP-1:0]  save_stb_o,
  output logic [NUM_GRP-1:0]  load_stb_o,
  output logic [NUM_REGS-1:0] shadow_q_o,
  output logic                pwr_off_ok_o,
  output logic                core_hold_o
);
  localparam int GW = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

  seq_state_t    state;
  logic          save_act, load_act;
  logic          save_final, load_final;
  logic [GW-1:0] save_grp, load_grp;

  assign save_act = (state == ST_SAVE);
  assign load_act = (state == ST_LOAD);

  pss_ctrl u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .shutdown_req_i (shutdown_req_i),
    .pwr_good_i     (pwr_good_i),
    .flush_ack_i    (flush_ack_i),
    .save_final_i   (save_final),
    .load_final_i   (load_final),
    .state_o        (state),
    .flush_req_o    (flush_req_o),
    .pwr_off_ok_o   (pwr_off_ok_o),
    .core_hold_o    (core_hold_o)
  );

  pss_step_walker #(.NUM_GRP(NUM_GRP), .HOLD(SAVE_HOLD)) u_save_walk (
    .clk      (clk),
    .rst      (rst),
    .active_i (save_act),
    .grp_o    (save_grp),
    .final_o  (save_final)
  );

  pss_step_walker #(.NUM_GRP(NUM_GRP), .HOLD(LOAD_HOLD)) u_load_walk (
    .clk      (clk),
    .rst      (rst),
    .active_i (load_act),
    .grp_o    (load_grp),
    .final_o  (load_final)
  );

  pss_strobe_dec #(.NUM_GRP(NUM_GRP)) u_save_dec (
    .clk   (clk),
    .rst   (rst),
    .en_i  (save_act),
    .grp_i (save_grp),
    .stb_o (save_stb_o)
  );

  pss_strobe_dec #(.NUM_GRP(NUM_GRP)) u_load_dec (
    .clk   (clk),
    .rst   (rst),
    .en_i  (load_act),
    .grp_i (load_grp),
    .stb_o (load_stb_o)
  );

  pss_shadow_bank #(.NUM_REGS(NUM_REGS), .GRP_SIZE(GRP_SIZE)) u_bank (
    .clk   (clk),
    .wr_i  (save_stb_o),
    .din_i (core_state_i),
    .q_o   (shadow_q_o)
  );
endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
  parameter int NUM_REGS = 1644,
  parameter int NUM_GRP  = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                pwr_good_i,
  input logic                flush_ack_i,
  input logic                flush_req_o,
  input logic [NUM_GRP-1:0]  save_stb_o,
  input logic [NUM_GRP-1:0]  load_stb_o,
  input logic [NUM_REGS-1:0] shadow_q_o,
  input logic                pwr_off_ok_o,
  input logic                core_hold_o
);
  // R3
  flush_held_chk: assert property (@(posedge clk) disable iff (rst)
    (flush_req_o && !flush_ack_i) |=> flush_req_o);

  // R4
  save_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(save_stb_o));

  // R7
  load_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(load_stb_o) && ((save_stb_o == '0) || (load_stb_o == '0)));

  // R5
  shadow_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (save_stb_o == '0) |=> $stable(shadow_q_o));

  // R6
  off_after_save_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_off_ok_o) |-> ($past(save_stb_o) != '0));

  // R6
  off_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_off_ok_o) |-> !$past(pwr_good_i, 2));

  // R6
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_off_ok_o |-> (save_stb_o == '0 && !flush_req_o));

  // R8
  hold_cover_chk: assert property (@(posedge clk) disable iff (rst)
    ((save_stb_o != '0) || (load_stb_o != '0)) |-> core_hold_o);
endmodule

bind pwr_state_seq pss_checker #(.NUM_REGS(NUM_REGS), .NUM_GRP(NUM_GRP)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .pwr_good_i   (pwr_good_i),
  .flush_ack_i  (flush_ack_i),
  .flush_req_o  (flush_req_o),
  .save_stb_o   (save_stb_o),
  .load_stb_o   (load_stb_o),
  .shadow_q_o   (shadow_q_o),
  .pwr_off_ok_o (pwr_off_ok_o),
  .core_hold_o  (core_hold_o)
);

// File: tb/test_pwr_state_seq.sv
`timescale 1ns/1ps
module test_pwr_state_seq;
  localparam int NR = 37;
  localparam int GS = 10;
  localparam int SH = 3;
  localparam int LH = 2;
  localparam int NG = (NR + GS - 1) / GS;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          shutdown_req = 1'b0;
  logic          pwr_good = 1'b1;
  logic          flush_ack = 1'b0;
  logic [NR-1:0] core_state = '0;
  logic          flush_req;
  logic [NG-1:0] save_stb, load_stb;
  logic [NR-1:0] shadow_q;
  logic          pwr_off_ok, core_hold;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pwr_state_seq #(.NUM_REGS(NR), .GRP_SIZE(GS), .SAVE_HOLD(SH), .LOAD_HOLD(LH)) i_pwr_state_seq (
    .clk            (clk),
    .rst            (rst),
    .shutdown_req_i (shutdown_req),
    .pwr_good_i     (pwr_good),
    .flush_ack_i    (flush_ack),
    .core_state_i   (core_state),
    .flush_req_o    (flush_req),
    .save_stb_o     (save_stb),
    .load_stb_o     (load_stb),
    .shadow_q_o     (shadow_q),
    .pwr_off_ok_o   (pwr_off_ok),
    .core_hold_o    (core_hold)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [NG-1:0] exp_stb(input int step, input int hold);
    exp_stb = NG'(1) << (step / hold);
  endfunction

  function automatic logic [NR-1:0] rand_state();
    rand_state = NR'({$urandom(), $urandom()});
  endfunction

  // Walks one strobe sequence. inject pulses shutdown_req mid-sequence.
  task automatic trace(input bit is_save, input bit inject);
    int          wait_cnt = 0;
    bit          ok = 1'b1;
    bit          side_ok = 1'b1;
    logic [NG-1:0] got = '0;
    logic [NG-1:0] want = '0;
    int          hold = is_save ? SH : LH;
    @(negedge clk);
    while ((is_save ? save_stb : load_stb) == '0 && wait_cnt < 10) begin
      @(negedge clk);
      wait_cnt++;
    end
    for (int i = 0; i < NG * hold; i++) begin
      if (i > 0) @(negedge clk);
      shutdown_req = (inject && i == 1);
      got = is_save ? save_stb : load_stb;
      if (ok && got != exp_stb(i, hold)) begin
        ok = 1'b0;
        want = exp_stb(i, hold);
        $display("FAIL %s step %0d: actual %0h expected %0h", is_save ? "R4" : "R7", i, got, want);
      end
      if (is_save && pwr_off_ok) side_ok = 1'b0;
      if (!core_hold) side_ok = 1'b0;
    end
    checks++;
    if (!ok) fails++;
    check(side_ok, "R8", "hold high and power-off low during strobes", 64'(side_ok), 64'd1);
    @(negedge clk);
    shutdown_req = 1'b0;
    got = is_save ? save_stb : load_stb;
    check(got == '0, is_save ? "R4" : "R7", "strobes idle after last group", 64'(got), 64'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    logic [NR-1:0] snap;
    bit pend = 1'b0;
    void'($urandom(32'h5EED_0C1A));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!flush_req, "R1", "flush_req", 64'(flush_req), 64'd0);
    check(save_stb == '0 && load_stb == '0, "R1", "strobes", 64'({save_stb, load_stb}), 64'd0);
    check(!pwr_off_ok && !core_hold, "R1", "off_ok/hold", 64'({pwr_off_ok, core_hold}), 64'd0);

    for (int it = 0; it < 8; it++) begin
      bit inj_save = (it % 3 == 1);
      bit inj_load = (it % 3 == 2);
      int k;
      core_state = rand_state();
      if (!pend) begin
        repeat ($urandom_range(1, 6)) @(negedge clk);
        shutdown_req = 1'b1;
        @(negedge clk);
        shutdown_req = 1'b0;
        check(flush_req, "R2", "flush_req one cycle after request", 64'(flush_req), 64'd1);
        check(core_hold, "R2", "core_hold one cycle after request", 64'(core_hold), 64'd1);
      end else begin
        for (int i = 0; i < 4 && !flush_req; i++) @(negedge clk);
        check(flush_req, "R9", "deferred shutdown starts flush", 64'(flush_req), 64'd1);
        pend = 1'b0;
      end
      snap = core_state;
      k = $urandom_range(0, 5);
      for (int i = 0; i < k; i++) begin
        @(negedge clk);
        check(save_stb == '0, "R2", "no save before flush ack", 64'(save_stb), 64'd0);
        check(flush_req, "R3", "flush_req held until ack", 64'(flush_req), 64'd1);
      end
      flush_ack = 1'b1;
      @(negedge clk);
      flush_ack = 1'b0;
      check(!flush_req, "R3", "flush_req drops after ack", 64'(flush_req), 64'd0);
      trace(1'b1, inj_save);
      check(pwr_off_ok, "R6", "power-off ok after last save group", 64'(pwr_off_ok), 64'd1);
      check(shadow_q == snap, "R5", "shadow after save", 64'(shadow_q), 64'(snap));
      core_state = rand_state();
      repeat ($urandom_range(2, 6)) @(negedge clk);
      check(shadow_q == snap, "R5", "shadow unchanged by core churn", 64'(shadow_q), 64'(snap));
      check(pwr_off_ok, "R6", "power-off ok held", 64'(pwr_off_ok), 64'd1);
      pwr_good = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(!pwr_off_ok, "R6", "power-off ok drops after power loss", 64'(pwr_off_ok), 64'd0);
      k = $urandom_range(2, 6);
      for (int i = 0; i < k; i++) begin
        @(negedge clk);
        check(load_stb == '0 && core_hold, "R7", "no load while power down",
              64'({load_stb, core_hold}), 64'd1);
      end
      core_state = rand_state();
      pwr_good = 1'b1;
      trace(1'b0, inj_load);
      check(shadow_q == snap, "R5", "shadow intact through restore", 64'(shadow_q), 64'(snap));
      if (inj_load) begin
        pend = 1'b1;
      end else begin
        check(!core_hold, "R8", "hold released after last load group", 64'(core_hold), 64'd0);
        if (inj_save) begin
          bit quiet = 1'b1;
          for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (flush_req || core_hold) quiet = 1'b0;
          end
          check(quiet, "R10", "request during save ignored", 64'(quiet), 64'd1);
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule